// File: doc/BRIEF.md
# Serial LED Status Shifter

This block gathers the status of a nine-port switch into a 24-bit LED frame and sends it out over two wires, a LED clock and a LED data line, to a chain of external shift registers. The frame carries twelve software-driven LEDs, one activity LED per front port, a collision LED for the highest port, a flow-control LED and a fault LED. The data line is active-low, so a 0 on the wire lights the LED in that position.

A pulse every 1/16 s divides time into intervals. During each interval the block records whether each port carried countable traffic, whether the top port saw a collision and whether flow control was asserted. At the next tick these records act on the LEDs. A port or collision LED toggles, so busy ports blink. The flow LED follows the interval just ended. The fault LED combines two latched error flags, each with its own clear input, and a software fault bit. While reset is held the block runs a lamp test. A separate active-low duplex output reports the state of the gigabit PCS.

Each burst starts by copying the whole frame into a shadow register. The 24 bits then go out one per LED clock period, followed by a short idle gap during which the clock stays high.

Top module: `led_status_shifter`

## Requirements
- R1: With order_sel_i = 0 the frame positions, in transmit order, are: positions 1-12 software bits sw_led_i[0..11], positions 13-21 port LEDs for ports 0..8, position 22 the collision LED, position 23 the flow LED and position 24 the fault LED. After reset every status LED is off.
- R2: With order_sel_i = 1 the frame positions are: positions 1-9 port LEDs for ports 0..8, position 10 the collision LED, positions 11-22 sw_led_i[0..11], position 23 flow and position 24 fault.
- R3: A port LED toggles on a tick_i cycle only if that port had port_frame_i high with port_pause_i low in some cycle of the interval that ended. An event in the tick cycle itself counts toward the next interval. Between ticks the LED holds its state.
- R4: When txmc_supp_i is 1, an event with port_txmc_i set on that port is not counted as activity. When txmc_supp_i is 0 it is counted.
- R5: The collision LED toggles on a tick if collision_i was seen during the interval that ended. It is shown off whenever pma_mode_i is 0.
- R6: The flow LED is on when flow_en_i is 1 and flow_assert_i was high in some cycle of the interval that ended at the last tick.
- R7: The fault LED is on when a parity flag, a CRC flag or sw_fault_i is set. crc_err_i sets the CRC flag and load_i clears it. parity_err_i sets the parity flag and start_i clears it. A clear wins over a set in the same cycle, and reset clears both flags.
- R8: The software LED bits show the value of sw_led_i at the moment the frame is captured.
- R9: While rst_n is low, led_data_o is 0, led_clk_o keeps toggling and dplx_n_o is 0.
- R10: dplx_n_o is 0 when pcs_en_i and pcs_fdx_i are both 1, and 1 otherwise outside reset.
- R11: A LED clock period is 2*HALF_PERIOD cycles (4 by default). led_data_o changes only on the cycle the clock falls, so it is stable while the clock is high. Each frame gives exactly 24 rising edges, and the clock stays high during the gap between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also selects lamp test |
| tick_i | input | 1 | One-cycle pulse marking each 1/16 s boundary |
| order_sel_i | input | 1 | Frame layout: 0 software LEDs first, 1 port LEDs first |
| sw_led_i | input | 12 | Software-controlled LED bits |
| port_frame_i | input | 9 | Per-port frame event pulse |
| port_pause_i | input | 9 | Qualifies the event as a pause frame |
| port_txmc_i | input | 9 | Qualifies the event as a transmitted multicast |
| txmc_supp_i | input | 1 | Drops transmit multicast from activity |
| collision_i | input | 1 | Collision pulse on the highest port |
| pma_mode_i | input | 1 | Highest port is in PMA mode |
| flow_en_i | input | 1 | Internal flow control enabled |
| flow_assert_i | input | 1 | Flow control asserted this cycle |
| crc_err_i | input | 1 | Sets the CRC error flag |
| parity_err_i | input | 1 | Sets the memory parity error flag |
| load_i | input | 1 | Clears the CRC flag |
| start_i | input | 1 | Clears the parity flag |
| sw_fault_i | input | 1 | Software fault bit |
| pcs_en_i | input | 1 | Gigabit PCS enabled |
| pcs_fdx_i | input | 1 | Gigabit PCS configured full duplex |
| led_clk_o | output | 1 | Serial LED clock |
| led_data_o | output | 1 | Serial LED data, active-low |
| dplx_n_o | output | 1 | Active-low full-duplex indicator |

## Verification
The assertions check on every cycle that the data line is steady while the LED clock is high, and that no activity LED moves between ticks or after a quiet interval. They also check that a CRC or parity error lights the fault LED on the next cycle, and that the lamp-test levels hold right after reset. Only the bench scenarios can show the two frame layouts bit by bit, the exclusion of pause and suppressed multicast traffic, the masking of the collision LED by PMA mode, the flow LED's one-interval delay and the separate clear of each fault flag. Those checks compare a decoded serial frame with the frame expected after the stimulus.

// File: rtl/led_stat_pkg.sv
// Package: shared types for the serial LED status shifter.
// Assumes: frame layouts are chosen by a single select bit.
package led_stat_pkg;

    // Frame layout selector.
    typedef enum logic {
        ORDER_SW_FIRST   = 1'b0,
        ORDER_PORT_FIRST = 1'b1
    } order_e;

    // Number of frame positions beyond software and port LEDs
    // (collision, flow, fault).
    localparam int FIXED_BITS = 3;

endpackage

// File: rtl/led_activity_tracker.sv
// Module: led_activity_tracker
// Records per-interval activity for each port, collision on the highest
// port and flow-control assertion, then applies them at each tick.
// Assumes: tick_i is a one-cycle pulse; events in the tick cycle belong
// to the next interval.
module led_activity_tracker #(
    parameter int NUM_PORTS = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [NUM_PORTS-1:0] port_frame_i,
    input  logic [NUM_PORTS-1:0] port_pause_i,
    input  logic [NUM_PORTS-1:0] port_txmc_i,
    input  logic                 txmc_supp_i,
    input  logic                 collision_i,
    input  logic                 flow_assert_i,
    output logic [NUM_PORTS-1:0] port_led_o,
    output logic                 col_led_o,
    output logic                 flow_active_o
);

    logic [NUM_PORTS-1:0] seen_q;
    logic [NUM_PORTS-1:0] hit;
    logic                 col_seen_q;
    logic                 flow_seen_q;

    // Qualify raw events: drop pause frames and optionally tx multicast.
    always_comb begin
        hit = port_frame_i & ~port_pause_i & ~({NUM_PORTS{txmc_supp_i}} & port_txmc_i);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Per-port interval record and blinking LED state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen_q[p]     <= 1'b0;
                port_led_o[p] <= 1'b0;
            end else if (tick_i) begin
                seen_q[p]     <= hit[p];
                port_led_o[p] <= port_led_o[p] ^ seen_q[p];
            end else begin
                seen_q[p]     <= seen_q[p] | hit[p];
            end
        end
    end

    // Collision record and blinking collision LED.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_seen_q <= 1'b0;
            col_led_o  <= 1'b0;
        end else if (tick_i) begin
            col_seen_q <= collision_i;
            col_led_o  <= col_led_o ^ col_seen_q;
        end else begin
            col_seen_q <= col_seen_q | collision_i;
        end
    end

    // Flow-control record; the LED reflects the previous interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flow_seen_q   <= 1'b0;
            flow_active_o <= 1'b0;
        end else if (tick_i) begin
            flow_seen_q   <= flow_assert_i;
            flow_active_o <= flow_seen_q;
        end else begin
            flow_seen_q   <= flow_seen_q | flow_assert_i;
        end
    end

    // R3: no LED moves on a cycle without a tick.
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(port_led_o));

    // R3: a tick after a quiet interval leaves the LEDs unchanged.
    a_r3_quiet_interval_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && seen_q == '0) |=> $stable(port_led_o));

endmodule

// File: rtl/led_fault_latch.sv
// Module: led_fault_latch
// Holds the CRC and parity error flags, each with its own clear input,
// and merges them with the software fault bit.
// Assumes: a clear in the same cycle as a set wins.
module led_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic crc_err_i,
    input  logic parity_err_i,
    input  logic load_i,
    input  logic start_i,
    input  logic sw_fault_i,
    output logic fault_o
);

    logic crc_q;
    logic par_q;

    // CRC flag: set by error, cleared by load.
    always_ff @(posedge clk) begin
        if (!rst_n)         crc_q <= 1'b0;
        else if (load_i)    crc_q <= 1'b0;
        else if (crc_err_i) crc_q <= 1'b1;
    end

    // Parity flag: set by error, cleared by start.
    always_ff @(posedge clk) begin
        if (!rst_n)            par_q <= 1'b0;
        else if (start_i)      par_q <= 1'b0;
        else if (parity_err_i) par_q <= 1'b1;
    end

    // Merge all fault sources.
    always_comb begin
        fault_o = crc_q | par_q | sw_fault_i;
    end

    // R7: a CRC error without a clear lights the fault LED next cycle.
    a_r7_crc_error_lights_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err_i && !load_i) |=> fault_o);

    // R7: a parity error without a clear lights the fault LED next cycle.
    a_r7_parity_error_lights_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err_i && !start_i) |=> fault_o);

endmodule

// File: rtl/led_frame_builder.sv
// Module: led_frame_builder
// Arranges the LED status into a frame vector whose MSB is sent first,
// in one of two layouts.
// Assumes: the collision, flow and fault bits occupy fixed places per layout.
module led_frame_builder #(
    parameter int NUM_PORTS = 9,
    parameter int SW_BITS   = 12,
    localparam int FRAME_LEN = SW_BITS + NUM_PORTS + led_stat_pkg::FIXED_BITS
) (
    input  led_stat_pkg::order_e   order_i,
    input  logic [SW_BITS-1:0]     sw_led_i,
    input  logic [NUM_PORTS-1:0]   port_led_i,
    input  logic                   col_led_i,
    input  logic                   flow_led_i,
    input  logic                   fault_led_i,
    output logic [FRAME_LEN-1:0]   frame_o
);

    // Place every status bit at its transmit position.
    always_comb begin
        frame_o    = '0;
        frame_o[1] = flow_led_i;
        frame_o[0] = fault_led_i;
        if (order_i == led_stat_pkg::ORDER_SW_FIRST) begin
            for (int i = 0; i < SW_BITS; i++)   frame_o[FRAME_LEN-1-i]         = sw_led_i[i];
            for (int p = 0; p < NUM_PORTS; p++) frame_o[FRAME_LEN-1-SW_BITS-p] = port_led_i[p];
            frame_o[2] = col_led_i;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) frame_o[FRAME_LEN-1-p]           = port_led_i[p];
            frame_o[FRAME_LEN-1-NUM_PORTS] = col_led_i;
            for (int i = 0; i < SW_BITS; i++)   frame_o[FRAME_LEN-2-NUM_PORTS-i] = sw_led_i[i];
        end
    end

endmodule

// File: rtl/led_serial_shifter.sv
// Module: led_serial_shifter
// Generates the divided LED clock, captures a frame at the start of each
// burst and shifts it out MSB first, with data changing as the clock falls.
// Runs the lamp test (data low, clock running) while reset is held.
// Assumes: the divider has no reset and recovers from any start value,
// so the clock keeps running during reset.
module led_serial_shifter #(
    parameter int FRAME_LEN   = 24,
    parameter int HALF_PERIOD = 2,
    parameter int GAP_SLOTS   = 2,
    localparam int SLOTS  = FRAME_LEN + GAP_SLOTS,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int DIV_W  = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FRAME_LEN-1:0] frame_i,
    output logic                 led_clk_o,
    output logic                 led_data_o,
    output logic                 lamp_o
);

    logic [DIV_W-1:0]     div_cnt;
    logic                 phase_q;
    logic                 half_end;
    logic                 slot_end;
    logic [SLOT_W-1:0]    slot_q;
    logic [FRAME_LEN-1:0] shadow_q;
    logic                 lamp_q;
    logic                 in_gap;

    assign half_end = (div_cnt >= DIV_W'(HALF_PERIOD - 1));
    assign slot_end = half_end & phase_q;
    assign in_gap   = (slot_q >= SLOT_W'(FRAME_LEN));

    // Free-running half-period divider.
    always_ff @(posedge clk) begin
        div_cnt <= half_end ? '0 : div_cnt + DIV_W'(1);
        phase_q <= half_end ? ~phase_q : phase_q;
    end

    // Slot sequencing, frame capture and shifting, lamp-test flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lamp_q   <= 1'b1;
            slot_q   <= SLOT_W'(SLOTS - 1);
            shadow_q <= '0;
        end else begin
            lamp_q <= 1'b0;
            if (slot_end) begin
                if (slot_q == SLOT_W'(SLOTS - 1)) begin
                    slot_q   <= '0;
                    shadow_q <= frame_i;
                end else begin
                    slot_q <= slot_q + SLOT_W'(1);
                    if (slot_q < SLOT_W'(FRAME_LEN - 1)) shadow_q <= shadow_q << 1;
                end
            end
        end
    end

    // Drive the wires: active-low data, clock held high in the gap.
    always_comb begin
        lamp_o     = lamp_q;
        led_clk_o  = lamp_q ? phase_q : (phase_q | in_gap);
        led_data_o = lamp_q ? 1'b0 : ~shadow_q[FRAME_LEN-1];
    end

    // R11: data is steady across any cycle pair with the clock high.
    a_r11_data_steady_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        (led_clk_o && $past(led_clk_o) && !$past(lamp_q)) |-> $stable(led_data_o));

endmodule

// File: rtl/led_status_shifter.sv
// Module: led_status_shifter (top)
// Tracks per-interval port, collision, flow and fault status, builds the
// LED frame and drives the two-wire serial LED interface plus the duplex LED.
// Assumes: tick_i pulses once per 1/16 s; the collision input belongs to
// the highest-numbered port.
module led_status_shifter #(
    parameter int NUM_PORTS   = 9,
    parameter int SW_BITS     = 12,
    parameter int HALF_PERIOD = 2,
    parameter int GAP_SLOTS   = 2,
    localparam int FRAME_LEN = SW_BITS + NUM_PORTS + led_stat_pkg::FIXED_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 order_sel_i,
    input  logic [SW_BITS-1:0]   sw_led_i,
    input  logic [NUM_PORTS-1:0] port_frame_i,
    input  logic [NUM_PORTS-1:0] port_pause_i,
    input  logic [NUM_PORTS-1:0] port_txmc_i,
    input  logic                 txmc_supp_i,
    input  logic                 collision_i,
    input  logic                 pma_mode_i,
    input  logic                 flow_en_i,
    input  logic                 flow_assert_i,
    input  logic                 crc_err_i,
    input  logic                 parity_err_i,
    input  logic                 load_i,
    input  logic                 start_i,
    input  logic                 sw_fault_i,
    input  logic                 pcs_en_i,
    input  logic                 pcs_fdx_i,
    output logic                 led_clk_o,
    output logic                 led_data_o,
    output logic                 dplx_n_o
);

    logic [NUM_PORTS-1:0] port_led;
    logic                 col_led;
    logic                 flow_active;
    logic                 fault_led;
    logic [FRAME_LEN-1:0] frame;
    logic                 lamp;
    led_stat_pkg::order_e order;

    assign order = led_stat_pkg::order_e'(order_sel_i);

    led_activity_tracker #(.NUM_PORTS(NUM_PORTS)) tracker_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .port_frame_i  (port_frame_i),
        .port_pause_i  (port_pause_i),
        .port_txmc_i   (port_txmc_i),
        .txmc_supp_i   (txmc_supp_i),
        .collision_i   (collision_i),
        .flow_assert_i (flow_assert_i),
        .port_led_o    (port_led),
        .col_led_o     (col_led),
        .flow_active_o (flow_active)
    );

    led_fault_latch fault_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .crc_err_i    (crc_err_i),
        .parity_err_i (parity_err_i),
        .load_i       (load_i),
        .start_i      (start_i),
        .sw_fault_i   (sw_fault_i),
        .fault_o      (fault_led)
    );

    led_frame_builder #(.NUM_PORTS(NUM_PORTS), .SW_BITS(SW_BITS)) builder_i (
        .order_i     (order),
        .sw_led_i    (sw_led_i),
        .port_led_i  (port_led),
        .col_led_i   (col_led & pma_mode_i),
        .flow_led_i  (flow_active & flow_en_i),
        .fault_led_i (fault_led),
        .frame_o     (frame)
    );

    led_serial_shifter #(
        .FRAME_LEN   (FRAME_LEN),
        .HALF_PERIOD (HALF_PERIOD),
        .GAP_SLOTS   (GAP_SLOTS)
    ) shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame),
        .led_clk_o  (led_clk_o),
        .led_data_o (led_data_o),
        .lamp_o     (lamp)
    );

    // Duplex LED: lit for enabled full-duplex PCS, and during lamp test.
    always_comb begin
        dplx_n_o = lamp ? 1'b0 : ~(pcs_en_i & pcs_fdx_i);
    end

    // R9: on the first cycle out of reset the lamp-test levels still hold.
    a_r9_lamp_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (led_data_o == 1'b0 && dplx_n_o == 1'b0));

endmodule

// File: tb/led_status_shifter_tb_top.sv
`timescale 1ns/1ps
module led_status_shifter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       order_sel_i = 1'b0;
    logic [11:0] sw_led_i = '0;
    logic [8:0] port_frame_i = '0, port_pause_i = '0, port_txmc_i = '0;
    logic       txmc_supp_i = 1'b0, collision_i = 1'b0, pma_mode_i = 1'b0;
    logic       flow_en_i = 1'b0, flow_assert_i = 1'b0;
    logic       crc_err_i = 1'b0, parity_err_i = 1'b0, load_i = 1'b0, start_i = 1'b0;
    logic       sw_fault_i = 1'b0, pcs_en_i = 1'b0, pcs_fdx_i = 1'b0;
    logic       led_clk_o, led_data_o, dplx_n_o;

    led_status_shifter dut_i (.*);

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // Bench model of the status, written from the requirements.
    logic [8:0] m_seen = '0, m_led = '0;
    logic m_col_seen = 0, m_col = 0, m_flow_seen = 0, m_flow_act = 0, m_crc = 0, m_par = 0;

    // Frame collector.
    logic [23:0] cur_frame = '0, last_frame = '0;
    int  idx = 0, hi_run = 0, frames = 0, t0 = 0, period_meas = 0;
    logic prev_clk = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            idx = 0; hi_run = 0; prev_clk = 1'b1;
        end else begin
            if (led_clk_o) begin
                hi_run++;
                if (hi_run > 4) idx = 0;
                if (!prev_clk) begin
                    if (idx == 0) t0 = cyc;
                    if (idx == 1) period_meas = cyc - t0;
                    cur_frame[23-idx] = ~led_data_o;
                    idx++;
                    if (idx == 24) begin
                        last_frame = cur_frame;
                        frames++;
                        idx = 0;
                    end
                end
            end else begin
                hi_run = 0;
            end
            prev_clk = led_clk_o;
        end
    end

    // Watchdog.
    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got cycle %0d expected finish before 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic logic [23:0] exp_frame();
        logic [23:0] f = '0;
        f[1] = flow_en_i & m_flow_act;
        f[0] = m_crc | m_par | sw_fault_i;
        if (!order_sel_i) begin
            for (int i = 0; i < 12; i++) f[23-i] = sw_led_i[i];
            for (int p = 0; p < 9; p++)  f[11-p] = m_led[p];
            f[2] = m_col & pma_mode_i;
        end else begin
            for (int p = 0; p < 9; p++)  f[23-p] = m_led[p];
            f[14] = m_col & pma_mode_i;
            for (int i = 0; i < 12; i++) f[13-i] = sw_led_i[i];
        end
        return f;
    endfunction

    task automatic check_val(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // One input cycle; the model follows what the requirements say happens at the edge.
    task automatic step(logic [8:0] fr, logic [8:0] ps, logic [8:0] mc, logic col, logic fa,
                        logic ce, logic pe, logic ld, logic st, logic tk);
        logic [8:0] hit;
        @(negedge clk);
        port_frame_i = fr; port_pause_i = ps; port_txmc_i = mc; collision_i = col;
        flow_assert_i = fa; crc_err_i = ce; parity_err_i = pe; load_i = ld; start_i = st; tick_i = tk;
        hit = fr & ~ps & ~({9{txmc_supp_i}} & mc);
        if (tk) begin
            m_led = m_led ^ m_seen; m_seen = hit;
            m_col = m_col ^ m_col_seen; m_col_seen = col;
            m_flow_act = m_flow_seen; m_flow_seen = fa;
        end else begin
            m_seen = m_seen | hit; m_col_seen = m_col_seen | col; m_flow_seen = m_flow_seen | fa;
        end
        if (ld) m_crc = 1'b0; else if (ce) m_crc = 1'b1;
        if (st) m_par = 1'b0; else if (pe) m_par = 1'b1;
    endtask

    task automatic idle();
        step('0, '0, '0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic tick();
        step('0, '0, '0, 0, 0, 0, 0, 0, 0, 1);
        idle();
    endtask

    task automatic check_frame(string tag);
        int f0 = frames;
        while (frames < f0 + 2) @(negedge clk);
        check_val(tag, {8'h0, last_frame}, {8'h0, exp_frame()});
    endtask

    initial begin
        int toggles = 0;
        logic prev;
        // R9 lamp test while held in reset.
        repeat (4) @(negedge clk);
        prev = led_clk_o;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (led_data_o !== 1'b0) check_val("R9 data low in reset", led_data_o, 0);
            if (led_clk_o != prev) toggles++;
            prev = led_clk_o;
        end
        check_val("R9 data low in reset", led_data_o, 0);
        check_val("R9 clock runs in reset", toggles >= 4, 1);
        check_val("R9 duplex lit in reset", dplx_n_o, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state: all off.
        check_frame("R1 reset frame all off");
        check_val("R11 clock period", period_meas, 4);

        // R10 duplex.
        pcs_en_i = 1; pcs_fdx_i = 1; @(negedge clk);
        check_val("R10 duplex lit", dplx_n_o, 0);
        pcs_fdx_i = 0; @(negedge clk);
        check_val("R10 half duplex dark", dplx_n_o, 1);

        // R3 pause-only traffic does not count; real traffic toggles.
        step(9'h008, 9'h008, '0, 0, 0, 0, 0, 0, 0, 0); tick();
        check_frame("R3 pause only no toggle");
        step(9'h008, '0, '0, 0, 0, 0, 0, 0, 0, 0); idle(); tick();
        check_frame("R3 traffic toggles on");
        tick();
        check_frame("R3 quiet interval holds");
        step(9'h008, '0, '0, 0, 0, 0, 0, 0, 0, 1); idle(); tick();
        check_frame("R3 tick-cycle event counts next interval");

        // R4 transmit multicast suppression.
        txmc_supp_i = 1;
        step(9'h020, '0, 9'h020, 0, 0, 0, 0, 0, 0, 0); tick();
        check_frame("R4 suppressed multicast ignored");
        txmc_supp_i = 0;
        step(9'h020, '0, 9'h020, 0, 0, 0, 0, 0, 0, 0); tick();
        check_frame("R4 multicast counted");

        // R5 collision and PMA mask.
        pma_mode_i = 0;
        step('0, '0, '0, 1, 0, 0, 0, 0, 0, 0); tick();
        check_frame("R5 collision masked off");
        pma_mode_i = 1;
        check_frame("R5 collision shown");

        // R6 flow.
        step('0, '0, '0, 0, 1, 0, 0, 0, 0, 0); tick();
        flow_en_i = 0;
        check_frame("R6 flow disabled off");
        flow_en_i = 1;
        check_frame("R6 flow on");
        tick();
        check_frame("R6 flow quiet interval off");

        // R7 fault sources and clears.
        step('0, '0, '0, 0, 0, 1, 0, 0, 0, 0); idle();
        check_frame("R7 crc sets fault");
        step('0, '0, '0, 0, 0, 0, 0, 1, 0, 0); idle();
        check_frame("R7 load clears crc");
        step('0, '0, '0, 0, 0, 0, 1, 0, 0, 0); step('0, '0, '0, 0, 0, 0, 0, 1, 0, 0); idle();
        check_frame("R7 load keeps parity");
        step('0, '0, '0, 0, 0, 0, 0, 0, 1, 0); idle();
        check_frame("R7 start clears parity");
        step('0, '0, '0, 0, 0, 1, 0, 1, 0, 0); idle();
        check_frame("R7 clear wins over set");
        sw_fault_i = 1;
        check_frame("R7 software fault");
        sw_fault_i = 0;

        // R8 and R2 layouts.
        sw_led_i = 12'hA5C;
        check_frame("R8 software bits A");
        sw_led_i = 12'h3E1; order_sel_i = 1;
        check_frame("R2 port-first layout");
        sw_led_i = 12'h0F7;
        check_frame("R8 software bits B");

        // Random mix: R1/R2 R3 R4 R5 R6 R7 R8.
        void'($urandom(32'h5EED));
        for (int it = 0; it < 40; it++) begin
            order_sel_i = $urandom & 1; sw_led_i = $urandom; pma_mode_i = $urandom & 1;
            flow_en_i = $urandom & 1; txmc_supp_i = $urandom & 1; sw_fault_i = ($urandom % 4) == 0;
            for (int c = 0; c < 6; c++) begin
                logic ld = ($urandom % 5) == 0, st = ($urandom % 5) == 0;
                step($urandom, $urandom, $urandom, $urandom & 1, $urandom & 1,
                     !ld && ($urandom % 6) == 0, !st && ($urandom % 6) == 0, ld, st,
                     ($urandom % 3) == 0);
            end
            idle();
            check_frame(order_sel_i ? "R2 random frame" : "R1 random frame");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule